// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's control path and handles the moment a handler is entered. When the core raises a request, the block looks at the pending synchronous exception code and at the external interrupt line. It picks one event, or none. It then commits the whole handler-entry state update in one clock: the saved copies of status, PC and R15, the new status word, the new PC and the cause codes.

Exceptions always beat interrupts. A block bit in the status word changes the outcome. With the bit set, a pending exception becomes a reset request, unless its code is the one that is allowed while blocked. An interrupt that arrives while the bit is set is dropped, unless the core is asleep.

The interrupt controller is outside this block. It receives the current 4-bit priority mask from the block and answers with a vector and a valid flag. The core samples the committed state while `taken_o` pulses. It also samples the separate `reset_req_o` pulse.

Top module: `exc_entry_seq`

## Requirements
- R1: When a request finds both an exception and an interrupt pending, the exception is taken (vector base +0x100 for a general code) and the interrupt cause output INTEVT is left unchanged.
- R2: When SR bit 28 (block) is set and an exception with a code other than 0x1E0 is pending, the request produces a one-cycle `reset_req_o` pulse. No handler is entered: `taken_o` stays low and all saved and committed state outputs are unchanged.
- R3: With SR bit 28 set, a pending exception of code 0x1E0 is entered normally, at vector base +0x100.
- R4: With SR bit 28 set, an interrupt is ignored unless `in_sleep_i` is high. When the core is asleep the interrupt is taken. Every taken event pulses `sleep_clr_o`.
- R5: `irq_mask_o` always equals SR[7:4]. An interrupt is taken only if `irq_vec_valid_i` is high. If it is low, nothing changes.
- R6: On every taken event, the following hold in the cycle after the request. SSR equals the input SR. SGR equals R15. The new SR equals the input SR with bits 28, 29 and 30 set. `resv_clr_o` pulses.
- R7: When `in_dslot_i` is high on a taken event, SPC is PC−2 and `dslot_clr_o` pulses. Otherwise SPC is PC and `dslot_clr_o` stays low.
- R8: Exception codes 0x000, 0x020 and 0x140 are reset-class. They clear SR bit 15, set SR[7:4] to 0xF and load PC with 0xA0000000.
- R9: Codes 0x040 and 0x060 load PC with vector base +0x400. Any other non-reset code loads vector base +0x100. EXPEVT receives the code on every exception.
- R10: A taken interrupt loads PC with vector base +0x600. INTEVT receives the controller vector, and EXPEVT is left unchanged.
- R11: Code 0x160 adds 2 to SPC, on top of any delay-slot rewind.
- R12: An interrupt is never taken while `in_dslot_i` is high.
- R13: `taken_o` and `reset_req_o` are single-cycle pulses and are never high together. With `req_i` low, nothing changes. After reset, every output register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Evaluate pending events this cycle |
| exc_pend_i | input | 1 | A synchronous exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_pend_i | input | 1 | External interrupt pending |
| irq_vec_valid_i | input | 1 | Controller has a vector above the current mask |
| irq_vec_i | input | 12 | Interrupt vector from the controller |
| irq_mask_o | output | 4 | Current priority mask, SR[7:4], to the controller |
| sr_i | input | 32 | Current status register |
| pc_i | input | 32 | Current PC |
| r15_i | input | 32 | Current general register 15 |
| vbr_i | input | 32 | Vector base |
| in_dslot_i | input | 1 | Current instruction sits in a delay slot |
| in_sleep_i | input | 1 | Core is sleeping |
| taken_o | output | 1 | Pulse: handler entry committed |
| reset_req_o | output | 1 | Pulse: masked exception escalated to reset |
| dslot_clr_o | output | 1 | Pulse: clear the delay-slot flag |
| sleep_clr_o | output | 1 | Pulse: clear the sleep flag |
| resv_clr_o | output | 1 | Pulse: drop any load-linked reservation |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved PC |
| sgr_o | output | 32 | Saved R15 |
| sr_o | output | 32 | Status to load on entry |
| pc_o | output | 32 | Handler entry PC |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt vector |

## Verification
Requests are driven with the exception and interrupt lines in each combination.

- The block bit is tried both clear and set, with the sleep and delay-slot flags toggled. This separates the reset-escalation, drop and take outcomes.
- The exception codes cover every vector class: reset-class, the two miss codes, the trap code, the code allowed while blocked, and a general code. A wrong code decode therefore shows up as a wrong PC or SR.
- The trap code is also raised inside a delay slot, to confirm that the two SPC adjustments combine.
- Idle cycles between events confirm that the pulses last one cycle and that the committed state holds.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    localparam int XLEN   = 32;
    localparam int CODE_W = 12;
    localparam int MASK_W = 4;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [CODE_W-1:0] code_t;

    // status word bit positions consumed by the core
    localparam int SR_FD     = 15;
    localparam int SR_BL     = 28;
    localparam int SR_RB     = 29;
    localparam int SR_MD     = 30;
    localparam int SR_MASK_L = 4;

    localparam code_t CODE_PWRON   = 12'h000;
    localparam code_t CODE_MANRST  = 12'h020;
    localparam code_t CODE_MULTIHT = 12'h140;
    localparam code_t CODE_MISS_RD = 12'h040;
    localparam code_t CODE_MISS_WR = 12'h060;
    localparam code_t CODE_TRAP    = 12'h160;
    localparam code_t CODE_BL_OK   = 12'h1E0;

    localparam word_t RESET_PC = 32'hA000_0000;
    localparam word_t OFS_GEN  = 32'h0000_0100;
    localparam word_t OFS_MISS = 32'h0000_0400;
    localparam word_t OFS_IRQ  = 32'h0000_0600;
    localparam word_t INSN_STEP = 32'd2;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_RESET,
        EV_EXC,
        EV_IRQ
    } ev_kind_e;

    typedef struct packed {
        word_t ssr;
        word_t spc;
        word_t sgr;
        word_t sr;
        word_t pc;
        code_t expevt;
        code_t intevt;
        logic  wr_exp;
        logic  wr_int;
    } entry_t;

    function automatic logic is_reset_class(code_t c);
        return (c == CODE_PWRON) || (c == CODE_MANRST) || (c == CODE_MULTIHT);
    endfunction

    function automatic logic is_miss(code_t c);
        return (c == CODE_MISS_RD) || (c == CODE_MISS_WR);
    endfunction
endpackage

// File: rtl/exc_decide.sv
module exc_decide
    import exc_seq_pkg::*;
(
    input  logic     req,
    input  logic     exc_pend,
    input  code_t    exc_code,
    input  logic     irq_pend,
    input  logic     irq_vec_valid,
    input  logic     blocked,
    input  logic     in_dslot,
    input  logic     in_sleep,
    output ev_kind_e kind
);
    logic irq_ok;

    // interrupts wait out delay slots and the block bit (unless asleep)
    assign irq_ok = irq_pend && irq_vec_valid && !in_dslot && (!blocked || in_sleep);

    always_comb begin
        kind = EV_NONE;
        if (req) begin
            if (exc_pend) begin
                kind = (blocked && (exc_code != CODE_BL_OK)) ? EV_RESET : EV_EXC;
            end else if (irq_ok) begin
                kind = EV_IRQ;
            end
        end
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_seq_pkg::*;
(
    input  ev_kind_e kind,
    input  code_t    exc_code,
    input  code_t    irq_vec,
    input  word_t    sr,
    input  word_t    pc,
    input  word_t    r15,
    input  word_t    vbr,
    input  logic     in_dslot,
    output entry_t   ent
);
    word_t rewind;
    word_t trap_adv;

    assign rewind   = in_dslot ? INSN_STEP : '0;
    assign trap_adv = (kind == EV_EXC && exc_code == CODE_TRAP) ? INSN_STEP : '0;

    always_comb begin
        ent        = '0;
        ent.ssr    = sr;
        ent.sgr    = r15;
        ent.spc    = pc - rewind + trap_adv;
        ent.sr     = sr;
        ent.sr[SR_BL] = 1'b1;
        ent.sr[SR_MD] = 1'b1;
        ent.sr[SR_RB] = 1'b1;
        ent.expevt = exc_code;
        ent.intevt = irq_vec;
        ent.wr_exp = (kind == EV_EXC);
        ent.wr_int = (kind == EV_IRQ);
        if (kind == EV_IRQ) begin
            ent.pc = vbr + OFS_IRQ;
        end else if (is_reset_class(exc_code)) begin
            ent.sr[SR_FD] = 1'b0;
            ent.sr[SR_MASK_L +: MASK_W] = '1;
            ent.pc = RESET_PC;
        end else if (is_miss(exc_code)) begin
            ent.pc = vbr + OFS_MISS;
        end else begin
            ent.pc = vbr + OFS_GEN;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              exc_pend_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_pend_i,
    input  logic              irq_vec_valid_i,
    input  logic [CODE_W-1:0] irq_vec_i,
    output logic [MASK_W-1:0] irq_mask_o,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   r15_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic              in_dslot_i,
    input  logic              in_sleep_i,
    output logic              taken_o,
    output logic              reset_req_o,
    output logic              dslot_clr_o,
    output logic              sleep_clr_o,
    output logic              resv_clr_o,
    output logic [XLEN-1:0]   ssr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   sgr_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   pc_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic [CODE_W-1:0] intevt_o
);
    ev_kind_e kind;
    entry_t   ent;
    logic     take;

    assign irq_mask_o = sr_i[SR_MASK_L +: MASK_W];

    exc_decide u_decide (
        .req           (req_i),
        .exc_pend      (exc_pend_i),
        .exc_code      (exc_code_i),
        .irq_pend      (irq_pend_i),
        .irq_vec_valid (irq_vec_valid_i),
        .blocked       (sr_i[SR_BL]),
        .in_dslot      (in_dslot_i),
        .in_sleep      (in_sleep_i),
        .kind          (kind)
    );

    exc_target u_target (
        .kind     (kind),
        .exc_code (exc_code_i),
        .irq_vec  (irq_vec_i),
        .sr       (sr_i),
        .pc       (pc_i),
        .r15      (r15_i),
        .vbr      (vbr_i),
        .in_dslot (in_dslot_i),
        .ent      (ent)
    );

    assign take = (kind == EV_EXC) || (kind == EV_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_o     <= 1'b0;
            reset_req_o <= 1'b0;
            dslot_clr_o <= 1'b0;
            sleep_clr_o <= 1'b0;
            resv_clr_o  <= 1'b0;
            ssr_o       <= '0;
            spc_o       <= '0;
            sgr_o       <= '0;
            sr_o        <= '0;
            pc_o        <= '0;
            expevt_o    <= '0;
            intevt_o    <= '0;
        end else begin
            taken_o     <= take;
            reset_req_o <= (kind == EV_RESET);
            dslot_clr_o <= take && in_dslot_i;
            sleep_clr_o <= take;
            resv_clr_o  <= take;
            if (take) begin
                ssr_o <= ent.ssr;
                spc_o <= ent.spc;
                sgr_o <= ent.sgr;
                sr_o  <= ent.sr;
                pc_o  <= ent.pc;
                if (ent.wr_exp) expevt_o <= ent.expevt;
                if (ent.wr_int) intevt_o <= ent.intevt;
            end
        end
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(taken_o && reset_req_o)); // R13
    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (rst)
        reset_req_o |-> $past(sr_i[SR_BL] && exc_pend_i && req_i)); // R2
    AST_RESET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        reset_req_o |-> $stable(pc_o) && $stable(spc_o)); // R2
    AST_IRQ_VEC: assert property (@(posedge clk) disable iff (rst)
        (taken_o && !$past(exc_pend_i)) |-> $past(irq_vec_valid_i)); // R5
    AST_IRQ_DSLOT: assert property (@(posedge clk) disable iff (rst)
        (taken_o && !$past(exc_pend_i)) |-> !$past(in_dslot_i)); // R12
    AST_ENTRY_SR: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (sr_o[SR_BL] && sr_o[SR_MD] && sr_o[SR_RB] && ssr_o == $past(sr_i))); // R6
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(req_i) |-> !taken_o && !reset_req_o); // R13
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, exc_pend = 1'b0, irq_pend = 1'b0, vec_ok = 1'b0;
    logic [11:0] code = '0, vec = '0;
    logic [31:0] sr = '0, pc = '0, r15 = '0, vbr = '0;
    logic        dslot = 1'b0, sleep = 1'b0;

    logic [3:0]  mask_o;
    logic        taken_o, rreq_o, dclr_o, sclr_o, rclr_o;
    logic [31:0] ssr_o, spc_o, sgr_o, sr_o, pc_o;
    logic [11:0] expevt_o, intevt_o;

    int n_chk = 0, n_fail = 0;

    // reference state
    logic        m_taken, m_rreq, m_dclr;
    logic [31:0] m_ssr, m_spc, m_sgr, m_sr, m_pc;
    logic [11:0] m_exp, m_int;

    always #5 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst(rst), .req_i(req), .exc_pend_i(exc_pend), .exc_code_i(code),
        .irq_pend_i(irq_pend), .irq_vec_valid_i(vec_ok), .irq_vec_i(vec), .irq_mask_o(mask_o),
        .sr_i(sr), .pc_i(pc), .r15_i(r15), .vbr_i(vbr), .in_dslot_i(dslot), .in_sleep_i(sleep),
        .taken_o(taken_o), .reset_req_o(rreq_o), .dslot_clr_o(dclr_o), .sleep_clr_o(sclr_o),
        .resv_clr_o(rclr_o), .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o), .sr_o(sr_o),
        .pc_o(pc_o), .expevt_o(expevt_o), .intevt_o(intevt_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural model of one clock edge, from the requirements
    task automatic model_edge();
        bit blk, go_exc, go_irq;
        int c;
        m_taken = 0; m_rreq = 0; m_dclr = 0;
        if (rst) begin
            {m_ssr, m_spc, m_sgr, m_sr, m_pc} = '0;
            m_exp = '0; m_int = '0;
            return;
        end
        blk = sr[28];
        c = int'(code);
        go_exc = 0; go_irq = 0;
        if (req && exc_pend) begin
            if (blk && c != 'h1E0) m_rreq = 1;
            else go_exc = 1;
        end else if (req && irq_pend && vec_ok && !dslot && (!blk || sleep)) begin
            go_irq = 1;
        end
        if (go_exc || go_irq) begin
            m_taken = 1;
            m_dclr = dslot;
            m_ssr = sr;
            m_sgr = r15;
            m_spc = dslot ? pc - 2 : pc;
            m_sr = sr | 32'h7000_0000;
            if (go_irq) begin
                m_pc = vbr + 'h600;
                m_int = vec;
            end else begin
                m_exp = code;
                if (c == 'h160) m_spc = m_spc + 2;
                if (c == 0 || c == 'h20 || c == 'h140) begin
                    m_sr[15] = 0;
                    m_sr[7:4] = 4'hF;
                    m_pc = 32'hA000_0000;
                end else if (c == 'h40 || c == 'h60) m_pc = vbr + 'h400;
                else m_pc = vbr + 'h100;
            end
        end
    endtask

    // one clock: inputs are stable from the previous negedge, compare at next negedge
    task automatic cycle(string tag);
        model_edge();
        @(negedge clk);
        chk(tag, "taken", 32'(taken_o), 32'(m_taken));
        chk(tag, "reset_req", 32'(rreq_o), 32'(m_rreq));
        chk(tag, "dslot_clr", 32'(dclr_o), 32'(m_dclr));
        chk(tag, "sleep_clr", 32'(sclr_o), 32'(m_taken));
        chk(tag, "resv_clr", 32'(rclr_o), 32'(m_taken));
        chk(tag, "ssr", ssr_o, m_ssr);
        chk(tag, "spc", spc_o, m_spc);
        chk(tag, "sgr", sgr_o, m_sgr);
        chk(tag, "sr", sr_o, m_sr);
        chk(tag, "pc", pc_o, m_pc);
        chk(tag, "expevt", 32'(expevt_o), 32'(m_exp));
        chk(tag, "intevt", 32'(intevt_o), 32'(m_int));
        chk("R5", "irq_mask", 32'(mask_o), 32'(sr[7:4]));
    endtask

    task automatic event_(string tag, logic e, logic [11:0] ec, logic i, logic iv,
                          logic [11:0] v, logic [31:0] s, logic ds, logic sl);
        req = 1; exc_pend = e; code = ec; irq_pend = i; vec_ok = iv; vec = v;
        sr = s; dslot = ds; sleep = sl;
        pc = pc + 32'h40; r15 = r15 + 32'h11;
        cycle(tag);
        req = 0;
        cycle("R13");
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        pc = 32'h0C00_1000; r15 = 32'h0000_8F00; vbr = 32'h8C00_0000;
        @(negedge clk);
        rst = 1;
        cycle("R13");
        cycle("R13");
        rst = 0;
        // pending lines with no request: nothing moves
        exc_pend = 1; code = 12'h180; irq_pend = 1; vec_ok = 1;
        cycle("R13");
        exc_pend = 0; irq_pend = 0;
        event_("R9",  1, 12'h180, 0, 0, 12'h000, 32'h0000_80A0, 0, 0);
        event_("R6",  1, 12'h0E0, 0, 0, 12'h000, 32'h0000_0031, 0, 0);
        event_("R9",  1, 12'h040, 0, 0, 12'h000, 32'h0000_0050, 0, 0);
        event_("R9",  1, 12'h060, 0, 0, 12'h000, 32'h0000_0050, 0, 0);
        event_("R8",  1, 12'h000, 0, 0, 12'h000, 32'h0000_8020, 0, 0);
        event_("R8",  1, 12'h020, 0, 0, 12'h000, 32'h0000_8030, 0, 0);
        event_("R8",  1, 12'h140, 0, 0, 12'h000, 32'h4000_8000, 0, 0);
        event_("R11", 1, 12'h160, 0, 0, 12'h000, 32'h0000_0000, 0, 0);
        event_("R11", 1, 12'h160, 0, 0, 12'h000, 32'h0000_0000, 1, 0);
        event_("R7",  1, 12'h180, 0, 0, 12'h000, 32'h0000_0070, 1, 0);
        event_("R10", 0, 12'h000, 1, 1, 12'h320, 32'h0000_0030, 0, 0);
        event_("R5",  0, 12'h000, 1, 0, 12'h340, 32'h0000_00F0, 0, 0);
        event_("R1",  1, 12'h1A0, 1, 1, 12'h360, 32'h0000_0000, 0, 0);
        event_("R2",  1, 12'h180, 0, 0, 12'h000, 32'h1000_0000, 0, 0);
        event_("R2",  1, 12'h040, 1, 1, 12'h380, 32'h1000_0000, 0, 0);
        event_("R3",  1, 12'h1E0, 0, 0, 12'h000, 32'h1000_0000, 0, 0);
        event_("R4",  0, 12'h000, 1, 1, 12'h3A0, 32'h1000_0000, 0, 0);
        event_("R4",  0, 12'h000, 1, 1, 12'h3C0, 32'h1000_0000, 0, 1);
        event_("R12", 0, 12'h000, 1, 1, 12'h3E0, 32'h0000_0000, 1, 0);
        event_("R10", 0, 12'h000, 1, 1, 12'h400, 32'h0000_0000, 0, 1);
        // back-to-back requests: pulses may repeat, never overlap
        req = 1; exc_pend = 1; code = 12'h180; sr = 32'h0; dslot = 0;
        cycle("R13");
        sr = 32'h1000_0000;
        cycle("R13");
        req = 0; exc_pend = 0;
        cycle("R13");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule